// File: doc/BRIEF.md
# NCO Baud Clock Generator

This block derives a serial-port reference clock, normally sixteen times the baud rate, from a fast system clock. It adds a programmable step to a 20-bit phase register on every system clock. Each time that addition wraps past the top of the register, the output level flips. The result is a square wave at Fsys × step / 2^21. With a 32 MHz system clock, a step of 120796 gives 1.8432 MHz, which is 16 × 115200 baud. A step of 241592 gives 3.6864 MHz (16 × 230400 baud), and a step of 2517 gives about 38.4 kHz (16 × 2400 baud, off by roughly 0.017 %).

Software builds the 20-bit step from its upper, high and low bytes. It presents the step on a parallel input and pulses a load strobe. The step is normally programmed while the generator is disabled. The enable input clears the phase register and holds the output low whenever it is deasserted, so every enable starts from a known phase.

Top module: `nco_baud_gen`

## Requirements
- R1: A synchronous active-high reset clears the phase register and the stored step to zero and drives the output low on the following edge.
- R2: While the enable is low, the output is low after each clock edge and the phase register is held at zero.
- R3: While the enable is high, each clock edge adds the stored step to the phase register modulo 2^20.
- R4: The output changes level on exactly those enabled edges where the 20-bit addition carries out, and it keeps its level on every other enabled edge. The first change after enabling is low to high.
- R5: When the load strobe is high at an edge, the step input is stored whether or not the block is enabled. That edge still uses the previous step, the stored value is used from the next edge on, and loading leaves the phase register unchanged. While the strobe is low, the stored step keeps its value.
- R6: With a stored step of zero, the output never changes level while enabled.
- R7: Starting from a cleared phase register, the output first goes high after ceil(2^20 / step) enabled edges. For a step of 120796 that is 9 edges, and for 2517 it is 417 edges.
- R8: The largest step, 2^20 − 1, is accepted. After the first enabled edge the addition carries on every edge, so the output toggles on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run the oscillator; low clears phase and forces output low |
| inc_value | input | 20 | Phase step to store |
| inc_load | input | 1 | Store `inc_value` at this edge |
| clk_out | output | 1 | Square-wave baud reference clock |

## Verification
On every cycle, the assertions check four things: the phase register advances by the stored step, the output flips only on a carry and holds otherwise, the disabled state forces zero phase and a low output, and a load captures its value exactly one edge later. Some properties span many cycles, and only the bench scenarios can show them. These are the edge count to the first rising output for the standard baud steps, the unchanged waveform across a step change made in mid-run, the silent output with a zero step, and the every-cycle toggling at the maximum step. A behavioural model compares the output against these expectations on every clock.

// File: rtl/nco_pkg.sv
package nco_pkg;

    // Width of the phase register and of the step value.
    parameter int unsigned PHASE_W = 20;

    typedef logic [PHASE_W-1:0] phase_t;

    // Result of one phase step: the wrapped sum and the carry out.
    typedef struct packed {
        logic   carry;
        phase_t sum;
    } phase_step_t;

    // Adds the step to the phase and returns the sum with its carry.
    function automatic phase_step_t phase_add(input phase_t cur, input phase_t step);
        logic [PHASE_W:0] wide;
        phase_step_t      r;
        wide    = {1'b0, cur} + {1'b0, step};
        r.carry = wide[PHASE_W];
        r.sum   = wide[PHASE_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/nco_inc_reg.sv
module nco_inc_reg
    import nco_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_i,
    input  phase_t value_i,
    output phase_t inc_o
);

    phase_t inc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            inc_q <= '0;
        end else if (load_i) begin
            inc_q <= value_i;
        end
    end

    assign inc_o = inc_q;

    // The stored step follows the strobe one edge later (R5).
    assert_load_capture_R5: assert property (@(posedge clk) disable iff (rst)
        load_i |=> inc_q == $past(value_i));

    assert_inc_held_R5: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(inc_q));

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
    import nco_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en_i,
    input  phase_t inc_i,
    output logic   carry_o,
    output phase_t acc_o
);

    phase_t      acc_q;
    phase_step_t step;

    always_comb begin
        step = phase_add(acc_q, inc_i);
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= step.sum;
        end
    end

    assign carry_o = en_i & step.carry;
    assign acc_o   = acc_q;

    // When disabled, the phase register is held at zero (R2).
    assert_hold_zero_disabled_R2: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> acc_q == '0);

    // When enabled, the phase advances by the step, wrapping at 2^20 (R3).
    assert_advance_by_step_R3: assert property (@(posedge clk) disable iff (rst)
        en_i |=> acc_q == phase_t'($past(acc_q) + $past(inc_i)));

    // A zero step never produces a carry (R6).
    assert_zero_step_no_carry_R6: assert property (@(posedge clk) disable iff (rst)
        (inc_i == '0) |-> !carry_o);

endmodule

// File: rtl/nco_toggle_out.sv
module nco_toggle_out (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic carry_i,
    output logic out_o
);

    logic out_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            out_q <= 1'b0;
        end else if (carry_i) begin
            out_q <= ~out_q;
        end
    end

    assign out_o = out_q;

    // When disabled, the output is low (R2).
    assert_out_low_disabled_R2: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !out_q);

    // An enabled carry flips the output (R4).
    assert_toggle_on_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (en_i && carry_i) |=> out_q != $past(out_q));

    // An enabled edge without a carry keeps the output level (R4).
    assert_steady_without_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (en_i && !carry_i) |=> $stable(out_q));

endmodule

// File: rtl/nco_baud_gen.sv
module nco_baud_gen
    import nco_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [PHASE_W-1:0] inc_value,
    input  logic              inc_load,
    output logic              clk_out
);

    phase_t inc_cur;
    phase_t acc_cur;
    logic   wrap;

    nco_inc_reg u_inc (
        .clk     (clk),
        .rst     (rst),
        .load_i  (inc_load),
        .value_i (inc_value),
        .inc_o   (inc_cur)
    );

    nco_phase_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en),
        .inc_i   (inc_cur),
        .carry_o (wrap),
        .acc_o   (acc_cur)
    );

    nco_toggle_out u_out (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en),
        .carry_i (wrap),
        .out_o   (clk_out)
    );

    // A load does not reset the phase register: it still advances by the old step (R5).
    assert_load_keeps_phase_R5: assert property (@(posedge clk) disable iff (rst)
        (inc_load && en) |=> acc_cur == phase_t'($past(acc_cur) + $past(inc_cur)));

    // The reset state is zero phase and a low output (R1).
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (acc_cur == '0) && (inc_cur == '0) && !clk_out);

endmodule

// File: tb/nco_baud_gen_tb_top.sv
module nco_baud_gen_tb_top;

    localparam int W = 20;
    localparam longint MODV = 64'd1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic [W-1:0] inc_value = '0;
    logic         inc_load = 1'b0;
    logic         clk_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit started = 1'b0;

    longint m_acc = 0;
    longint m_inc = 0;
    bit     m_out = 1'b0;

    always #2.5 clk = ~clk;

    nco_baud_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .inc_value (inc_value),
        .inc_load  (inc_load),
        .clk_out   (clk_out)
    );

    task automatic check(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    task automatic check_int(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Behavioural reference model, updated at every edge.
    always @(posedge clk) begin
        longint nxt_inc;
        longint s;
        cycles++;
        started = 1'b1;
        nxt_inc = inc_load ? longint'(inc_value) : m_inc;
        if (rst) begin
            m_acc = 0; m_out = 1'b0; nxt_inc = 0;
        end else if (!en) begin
            m_acc = 0; m_out = 1'b0;
        end else begin
            s = m_acc + m_inc;
            if (s >= MODV) begin
                s = s - MODV;
                m_out = ~m_out;
            end
            m_acc = s;
        end
        m_inc = nxt_inc;
    end

    // Compare against the model in the middle of every cycle.
    always @(negedge clk) begin
        if (started) begin
            if (rst)      check(clk_out, m_out, "R1 model");
            else if (!en) check(clk_out, m_out, "R2 model");
            else          check(clk_out, m_out, "R3 R4 model");
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected below 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic load_step(input int v);
        @(negedge clk);
        inc_value = W'(v);
        inc_load  = 1'b1;
        @(negedge clk);
        inc_load  = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Enable from the disabled state and count edges until the first high output.
    task automatic first_rise(input int exp, input string tag);
        int cnt = 0;
        @(negedge clk);
        en = 1'b1;
        do begin
            @(negedge clk);
            cnt++;
        end while (clk_out == 1'b0 && cnt < 2000);
        check_int(cnt, exp, tag);
    endtask

    initial begin
        bit held;
        int flips;
        run(4);
        check(clk_out, 1'b0, "R1 reset output low");
        @(negedge clk);
        rst = 1'b0;

        // 16 x 115200 step, loaded while disabled.
        load_step(120796);
        run(3);
        check(clk_out, 1'b0, "R2 disabled output low");
        first_rise(9, "R7 first rise for 120796");
        run(2000);

        // Disable: output low and phase cleared.
        @(negedge clk);
        en = 1'b0;
        run(1);
        check(clk_out, 1'b0, "R2 output low after disable");
        run(5);

        // 16 x 2400 step.
        load_step(2517);
        first_rise(417, "R7 first rise for 2517");
        run(1200);

        // Step change while running (R5).
        load_step(241592);
        run(500);

        // Zero step: output static (R6).
        load_step(0);
        run(2);
        held = clk_out;
        flips = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (clk_out != held) flips++;
        end
        check_int(flips, 0, "R6 zero step static");

        // Largest step toggles every clock after the first edge (R8).
        @(negedge clk);
        en = 1'b0;
        load_step((1 << W) - 1);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        held = clk_out;
        check(clk_out, 1'b0, "R8 no carry on first edge");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(clk_out, ~held, "R8 toggles every clock");
            held = clk_out;
        end

        // Reset in mid-run (R1).
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(clk_out, 1'b0, "R1 reset mid-run");
        rst = 1'b0;
        run(20);
        check(clk_out, 1'b0, "R1 step cleared by reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule